// File: doc/BRIEF.md
# Word-Granular Read Mark Validator

This block sits beside a small L1 line array inside a transactional core. It records, one bit per 32-bit word, which parts of each line a running transaction has loaded. When a line is held with stale data, a transactional load is answered at once from that copy, with the same latency as a hit, and a refetch of the line is requested. When fresh data for a line comes back, the block compares only the words the transaction has actually read against the fresh copy. The transaction is killed only if one of those words differs. A change elsewhere in the line, such as a neighbour's variable sharing the same line, leaves it alone.

A load names a line slot, a byte offset within the 64-byte line, and the line's state as seen by the cache (absent, valid or stale). A fill delivers a whole line, which always replaces the stored copy. Begin, commit and abort strobes frame each transaction. A per-line read-set vector tells the surrounding logic which lines the running transaction depends on.

Top module: `tvp_read_validator`

## Requirements
- R1: While reset is applied, and after it is released, `ld_rvalid`, `fetch_req`, `val_abort` and every bit of `rd_set` are 0.
- R2: A load with state 1 (valid) returns, on the cycle after it is presented, `ld_rvalid`=1 and the stored word of that line selected by `ld_offset[5:2]`. Word w of a line occupies bits [32w+31:32w] of `fill_data`, and `ld_offset[1:0]` has no effect. No fetch request follows.
- R3: A load with state 2 (stale) returns the stored word with the same one-cycle timing as R2. In the same cycle it raises `fetch_req` for one cycle, with `fetch_line` equal to the loaded line.
- R4: A load with state 0 (absent) produces neither `ld_rvalid` nor `fetch_req`, and sets no read mark.
- R5: A valid or stale load made inside a transaction sets the mark of the word it read. `rd_set[i]` is the OR of the 16 marks of line i. Loads made outside a transaction set no mark.
- R6: A stale load to a line whose refetch is still outstanding raises no new `fetch_req`. A fill to that line ends the outstanding state, so a later stale load requests again.
- R7: A fill whose data differs from the stored line only in words that carry no mark raises no `val_abort`, and it keeps the existing marks.
- R8: A fill that differs in any marked word raises `val_abort` for exactly one cycle, the cycle after the fill is accepted. It clears every mark and ends the transaction, so later loads set no marks until the next begin.
- R9: Every fill overwrites the stored line with the fill data, whether or not validation fails.
- R10: Begin, commit and abort each clear all marks, so `rd_set` is 0 on the following cycle. A fill that arrives after the clear cannot raise `val_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | End the transaction successfully |
| tx_abort | input | 1 | End the transaction by external abort |
| ld_valid | input | 1 | Load request strobe |
| ld_line | input | 2 | Line slot addressed by the load |
| ld_offset | input | 6 | Byte offset within the line |
| ld_state | input | 2 | Line state: 0 absent, 1 valid, 2 stale |
| fill_valid | input | 1 | Fresh line data present |
| fill_line | input | 2 | Line slot the fill targets |
| fill_data | input | 512 | Full line, word w at bits [32w+31:32w] |
| ld_rvalid | output | 1 | Load data valid |
| ld_rdata | output | 32 | Load data word |
| fetch_req | output | 1 | Request to refetch a stale line |
| fetch_line | output | 2 | Line slot to refetch |
| val_abort | output | 1 | Validation failed; transaction killed |
| rd_set | output | 4 | Per-line read-set membership |

## Verification
A mark lost or set on the wrong word shows up only at the next fill to that line. The `val_abort` pulse then either fails to appear or appears when it should not, one cycle after the fill. For this reason the tests pair every mark they set with a fill that changes marked and unmarked words separately. A stuck refetch-pending bit shows as a missing or duplicated `fetch_req` on the next stale load to that line. A stored line that was not overwritten shows as wrong `ld_rdata` on the first load after a fill. `rd_set` exposes the OR of every mark directly, the cycle after each load or clear.

// File: rtl/tvp_pkg.sv
package tvp_pkg;
  typedef enum logic [1:0] {
    LS_ABSENT = 2'd0,
    LS_VALID  = 2'd1,
    LS_STALE  = 2'd2
  } line_state_e;
endpackage

// File: rtl/tvp_mark_array.sv
module tvp_mark_array #(
  parameter int NL  = 4,
  parameter int WPL = 16,
  localparam int LW = $clog2(NL),
  localparam int WW = $clog2(WPL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [LW-1:0]           set_line,
  input  logic [WW-1:0]           set_word,
  input  logic                    clr_all,
  output logic [NL-1:0][WPL-1:0]  marks_o,
  output logic [NL-1:0]           rd_set_o
);
  logic [NL-1:0][WPL-1:0] marks_q, marks_d;

  always_comb begin
    marks_d = marks_q;
    if (clr_all)
      marks_d = '0;
    else if (set_en)
      marks_d[set_line][set_word] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) marks_q <= '0;
    else        marks_q <= marks_d;
  end

  assign marks_o = marks_q;

  for (genvar g = 0; g < NL; g++) begin : g_rdset
    assign rd_set_o[g] = |marks_q[g];
  end
endmodule

// File: rtl/tvp_fetch_tracker.sv
module tvp_fetch_tracker #(
  parameter int NL = 4,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stale_ld,
  input  logic [LW-1:0] ld_line,
  input  logic          fill_valid,
  input  logic [LW-1:0] fill_line,
  output logic          fetch_req,
  output logic [LW-1:0] fetch_line
);
  logic [NL-1:0] pend_q, pend_d;
  logic          req_q;
  logic [LW-1:0] line_q;
  logic          issue;

  assign issue = stale_ld && !pend_q[ld_line];

  always_comb begin
    pend_d = pend_q;
    if (fill_valid) pend_d[fill_line] = 1'b0;
    if (issue)      pend_d[ld_line]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      req_q  <= 1'b0;
      line_q <= '0;
    end else begin
      pend_q <= pend_d;
      req_q  <= issue;
      if (issue) line_q <= ld_line;
    end
  end

  assign fetch_req  = req_q;
  assign fetch_line = line_q;
endmodule

// File: rtl/tvp_line_store.sv
module tvp_line_store #(
  parameter int NL  = 4,
  parameter int WPL = 16,
  parameter int DW  = 32,
  localparam int LW = $clog2(NL),
  localparam int WW = $clog2(WPL),
  localparam int LB = WPL * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [LW-1:0]  rd_line,
  input  logic [WW-1:0]  rd_word,
  input  logic           wr_en,
  input  logic [LW-1:0]  wr_line,
  input  logic [LB-1:0]  wr_data,
  input  logic [WPL-1:0] wr_marks,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           mismatch
);
  logic [LB-1:0]  mem_q [NL];
  logic [LB-1:0]  old_line;
  logic [WPL-1:0] diff;
  logic           rv_q;
  logic [DW-1:0]  rd_q;

  for (genvar g = 0; g < NL; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en && (wr_line == LW'(g))) mem_q[g] <= wr_data;
    end
  end

  assign old_line = mem_q[wr_line];

  for (genvar w = 0; w < WPL; w++) begin : g_cmp
    assign diff[w] = old_line[w*DW +: DW] != wr_data[w*DW +: DW];
  end

  assign mismatch = wr_en && |(diff & wr_marks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) rd_q <= mem_q[rd_line][rd_word*DW +: DW];
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/tvp_read_validator.sv
module tvp_read_validator #(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  localparam int WPL   = LINE_BYTES / WORD_BYTES,
  localparam int DW    = WORD_BYTES * 8,
  localparam int LW    = $clog2(NUM_LINES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int WB_W  = $clog2(WORD_BYTES),
  localparam int WW    = $clog2(WPL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_begin,
  input  logic                   tx_commit,
  input  logic                   tx_abort,
  input  logic                   ld_valid,
  input  logic [LW-1:0]          ld_line,
  input  logic [OFF_W-1:0]       ld_offset,
  input  logic [1:0]             ld_state,
  input  logic                   fill_valid,
  input  logic [LW-1:0]          fill_line,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic                   ld_rvalid,
  output logic [DW-1:0]          ld_rdata,
  output logic                   fetch_req,
  output logic [LW-1:0]          fetch_line,
  output logic                   val_abort,
  output logic [NUM_LINES-1:0]   rd_set
);
  import tvp_pkg::*;

  logic [1:0] sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  line_state_e st;
  logic        ld_hit, ld_stale, mark_en, clr_marks, mismatch;
  logic        in_tx_q, in_tx_d, abort_q;
  logic [WW-1:0] word_idx;
  logic [NUM_LINES-1:0][WPL-1:0] marks;

  assign st       = line_state_e'(ld_state);
  assign ld_hit   = ld_valid && (st == LS_VALID || st == LS_STALE);
  assign ld_stale = ld_valid && (st == LS_STALE);
  assign word_idx = ld_offset[OFF_W-1:WB_W];
  assign mark_en  = ld_hit && in_tx_q;
  assign clr_marks = tx_begin || tx_commit || tx_abort || mismatch;

  always_comb begin
    in_tx_d = in_tx_q;
    if (tx_begin) in_tx_d = 1'b1;
    if (tx_commit || tx_abort || mismatch) in_tx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      in_tx_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      in_tx_q <= in_tx_d;
      abort_q <= mismatch;
    end
  end

  tvp_mark_array #(.NL(NUM_LINES), .WPL(WPL)) u_marks (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (mark_en),
    .set_line (ld_line),
    .set_word (word_idx),
    .clr_all  (clr_marks),
    .marks_o  (marks),
    .rd_set_o (rd_set)
  );

  tvp_fetch_tracker #(.NL(NUM_LINES)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stale_ld   (ld_stale),
    .ld_line    (ld_line),
    .fill_valid (fill_valid),
    .fill_line  (fill_line),
    .fetch_req  (fetch_req),
    .fetch_line (fetch_line)
  );

  tvp_line_store #(.NL(NUM_LINES), .WPL(WPL), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (ld_hit),
    .rd_line  (ld_line),
    .rd_word  (word_idx),
    .wr_en    (fill_valid),
    .wr_line  (fill_line),
    .wr_data  (fill_data),
    .wr_marks (marks[fill_line]),
    .rd_valid (ld_rvalid),
    .rd_data  (ld_rdata),
    .mismatch (mismatch)
  );

  assign val_abort = abort_q;
endmodule

// File: rtl/tvp_checker.sv
module tvp_checker #(
  parameter int NL = 4,
  localparam int LW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_commit,
  input logic          tx_abort,
  input logic          ld_valid,
  input logic [1:0]    ld_state,
  input logic          fill_valid,
  input logic [LW-1:0] fill_line,
  input logic          ld_rvalid,
  input logic          fetch_req,
  input logic [LW-1:0] fetch_line,
  input logic          val_abort,
  input logic [NL-1:0] rd_set
);
  logic [NL-1:0] seen_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_pend <= '0;
    else begin
      if (fetch_req)  seen_pend[fetch_line] <= 1'b1;
      if (fill_valid) seen_pend[fill_line]  <= 1'b0;
    end
  end

  p_load_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_state == 2'd1 || ld_state == 2'd2)) |=> ld_rvalid);

  p_valid_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_state == 2'd1) |=> !fetch_req);

  p_absent_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_state == 2'd0) |=> (!ld_rvalid && !fetch_req));

  p_no_dup_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !seen_pend[fetch_line]);

  p_abort_needs_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    val_abort |-> $past(fill_valid));

  p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    val_abort |=> !val_abort);

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    val_abort |-> (rd_set == '0));

  p_end_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit || tx_abort) |=> (rd_set == '0));
endmodule

bind tvp_read_validator tvp_checker #(.NL(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tx_commit  (tx_commit),
  .tx_abort   (tx_abort),
  .ld_valid   (ld_valid),
  .ld_state   (ld_state),
  .fill_valid (fill_valid),
  .fill_line  (fill_line),
  .ld_rvalid  (ld_rvalid),
  .fetch_req  (fetch_req),
  .fetch_line (fetch_line),
  .val_abort  (val_abort),
  .rd_set     (rd_set)
);

// File: tb/tb_tvp_read_validator.sv
module tb_tvp_read_validator;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_begin, tx_commit, tx_abort;
  logic         ld_valid;
  logic [1:0]   ld_line;
  logic [5:0]   ld_offset;
  logic [1:0]   ld_state;
  logic         fill_valid;
  logic [1:0]   fill_line;
  logic [511:0] fill_data;
  logic         ld_rvalid;
  logic [31:0]  ld_rdata;
  logic         fetch_req;
  logic [1:0]   fetch_line;
  logic         val_abort;
  logic [3:0]   rd_set;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_mem [4][16];

  always #4 clk = ~clk;

  tvp_read_validator dut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .ld_valid(ld_valid), .ld_line(ld_line),
    .ld_offset(ld_offset), .ld_state(ld_state), .fill_valid(fill_valid),
    .fill_line(fill_line), .fill_data(fill_data), .ld_rvalid(ld_rvalid),
    .ld_rdata(ld_rdata), .fetch_req(fetch_req), .fetch_line(fetch_line),
    .val_abort(val_abort), .rd_set(rd_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int line, input int word, input int seed);
    return {8'(seed), 8'(line), 8'(word), 8'h5A};
  endfunction

  task automatic do_load(input int line, input int off, input logic [1:0] st);
    ld_valid = 1'b1; ld_line = 2'(line); ld_offset = 6'(off); ld_state = st;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_fill(input int line, input int seed, input logic [15:0] chg);
    for (int w = 0; w < 16; w++) begin
      if (chg[w]) exp_mem[line][w] = pat(line, w, seed);
      fill_data[w*32 +: 32] = exp_mem[line][w];
    end
    fill_valid = 1'b1; fill_line = 2'(line);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    tx_begin = (which == 0); tx_commit = (which == 1); tx_abort = (which == 2);
    @(negedge clk);
    tx_begin = 1'b0; tx_commit = 1'b0; tx_abort = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ld_rvalid", 32'(ld_rvalid), 0);
    chk("R1 fetch_req", 32'(fetch_req), 0);
    chk("R1 val_abort", 32'(val_abort), 0);
    chk("R1 rd_set", 32'(rd_set), 0);
  endtask

  task automatic t_preload;
    for (int l = 0; l < 4; l++) begin
      do_fill(l, 1, 16'hFFFF);
      chk("R7 preload no abort", 32'(val_abort), 0);
    end
  endtask

  task automatic t_valid_load;
    do_load(1, 6'h17, 2'd1);
    chk("R2 rvalid", 32'(ld_rvalid), 1);
    chk("R2 data word5", ld_rdata, exp_mem[1][5]);
    chk("R2 no fetch", 32'(fetch_req), 0);
    chk("R5 no mark outside tx", 32'(rd_set), 0);
    do_load(3, 6'h3F, 2'd1);
    chk("R2 data word15 low bits ignored", ld_rdata, exp_mem[3][15]);
  endtask

  task automatic t_absent;
    pulse(0);
    do_load(2, 6'h08, 2'd0);
    chk("R4 no rvalid", 32'(ld_rvalid), 0);
    chk("R4 no fetch", 32'(fetch_req), 0);
    chk("R4 no mark", 32'(rd_set), 0);
  endtask

  task automatic t_stale;
    do_load(2, 6'h0C, 2'd2);
    chk("R3 rvalid", 32'(ld_rvalid), 1);
    chk("R3 stale data", ld_rdata, exp_mem[2][3]);
    chk("R3 fetch_req", 32'(fetch_req), 1);
    chk("R3 fetch_line", 32'(fetch_line), 2);
    chk("R5 rd_set line2", 32'(rd_set), 32'h4);
  endtask

  task automatic t_pending;
    do_load(2, 6'h1C, 2'd2);
    chk("R6 no second fetch", 32'(fetch_req), 0);
    chk("R3 data word7", ld_rdata, exp_mem[2][7]);
  endtask

  task automatic t_fill_pass;
    do_fill(2, 2, 16'h0401);
    chk("R7 unmarked change no abort", 32'(val_abort), 0);
    @(negedge clk);
    chk("R7 still no abort", 32'(val_abort), 0);
    chk("R7 marks kept", 32'(rd_set), 32'h4);
    do_load(2, 6'h28, 2'd1);
    chk("R9 new data after pass", ld_rdata, exp_mem[2][10]);
    do_load(2, 6'h00, 2'd2);
    chk("R6 refetch after fill", 32'(fetch_req), 1);
  endtask

  task automatic t_fill_fail;
    do_fill(2, 3, 16'h0008);
    chk("R8 abort pulse", 32'(val_abort), 1);
    chk("R8 marks cleared", 32'(rd_set), 0);
    @(negedge clk);
    chk("R8 abort one cycle", 32'(val_abort), 0);
    do_load(2, 6'h0C, 2'd1);
    chk("R9 new data after fail", ld_rdata, exp_mem[2][3]);
    chk("R8 tx ended no mark", 32'(rd_set), 0);
  endtask

  task automatic t_commit_abort;
    pulse(0);
    do_load(0, 6'h04, 2'd1);
    do_load(3, 6'h10, 2'd1);
    chk("R5 rd_set two lines", 32'(rd_set), 32'h9);
    pulse(1);
    chk("R10 commit clears", 32'(rd_set), 0);
    do_fill(0, 4, 16'h0002);
    chk("R10 no abort after commit", 32'(val_abort), 0);
    pulse(0);
    do_load(1, 6'h20, 2'd1);
    chk("R5 rd_set line1", 32'(rd_set), 32'h2);
    pulse(2);
    chk("R10 abort clears", 32'(rd_set), 0);
    chk("R10 no val_abort on ext abort", 32'(val_abort), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    tx_begin = 0; tx_commit = 0; tx_abort = 0;
    ld_valid = 0; ld_line = 0; ld_offset = 0; ld_state = 0;
    fill_valid = 0; fill_line = 0; fill_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_preload();
    t_valid_load();
    t_absent();
    t_stale();
    t_pending();
    t_fill_pass();
    t_fill_fail();
    t_commit_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule